// File: doc/BRIEF.md
# Multithreaded Lookahead Issue Stage

This block is the issue stage of a barrel processor that keeps many hardware instruction streams in flight. On every clock it looks at all streams, selects one that is ready, and issues that stream's next instruction. Instead of comparing register numbers, each instruction carries a 3-bit lookahead count supplied by the compiler. The count is the number of later instructions of the same stream that may issue before one of them depends on this instruction.

Each stream keeps an 8-bit issue sequence number and a small table of instructions still in execution. For each entry the table stores the sequence number and an expiry index, which is the issue index plus the lookahead plus one. A stream is blocked while any outstanding entry has an expiry index at or below the stream's next index. Completions come back from a pipeline with variable latency. Each completion carries a stream id and a sequence number, and it frees the matching entry. A round-robin picker shares the single issue slot among the streams that are ready.

Top module: `mt_lookahead_issue`

## Requirements
- R1: After reset every stream's sequence number is 0, no instruction is outstanding, and no instruction issues while no stream is both active and holding a valid instruction.
- R2: At most one instruction issues per clock. When at least one stream is ready, an instruction issues in that same cycle (the `issue_*` outputs are combinational).
- R3: The sequence numbers a stream issues are 0, 1, 2, and so on, counted modulo 256 independently for each stream. The value is reported on `issue_seq` together with `issue_la`, which is the issued instruction's lookahead.
- R4: While instruction k of a stream, issued with lookahead L, is still outstanding, instructions k+1 to k+L may issue and instruction k+L+1 is held back.
- R5: A lookahead of 7 lets all of the next seven instructions of the stream issue while the instruction is still outstanding.
- R6: A completion whose stream id and sequence number match an outstanding entry frees that entry from the next cycle on. A completion that matches no outstanding entry has no effect.
- R7: No stream ever has more than DEPTH (8) outstanding instructions. A stream whose table is full does not issue.
- R8: The picker searches from the stream after the last issued stream, wrapping from stream N-1 to stream 0, and issues the first ready stream it finds. After reset the search starts at stream 0.
- R9: A stream whose `strm_active` bit or `instr_valid` bit is low never issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strm_active | input | N | One bit per stream: the stream is running |
| instr_valid | input | N | One bit per stream: the stream's next instruction is available |
| instr_la | input | 3*N | Lookahead of each stream's next instruction; stream s uses bits [3s+2:3s] |
| cmpl_valid | input | 1 | A completion is present this cycle |
| cmpl_stream | input | log2 N | Stream id of the completion |
| cmpl_seq | input | 8 | Sequence number of the completed instruction |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_stream | output | log2 N | Stream that issues |
| issue_seq | output | 8 | Sequence number of the issued instruction |
| issue_la | output | 3 | Lookahead of the issued instruction |

## Verification
The bench targets the expiry boundary. An off-by-one there would let instruction k+L+1 issue too early, or would stall instruction k+L. It also sends completions that name a sequence number not yet issued, to catch a design that clears entries by stream id alone and unblocks the stream before its real completion arrives. The search order is checked across the wrap from stream 127 to stream 0: a fixed-priority picker, or one that restarts at the last issued stream, would pick the wrong stream. Finally, one stream issues more than 256 instructions, so the sequence numbers wrap, and a non-modular comparison would then block that stream forever.

// File: rtl/mt_issue_pkg.sv
// Package: shared widths and the sequence comparison used by the issue stage.
// Assumes fewer than half the sequence space is in flight for any stream.
package mt_issue_pkg;
    parameter int unsigned SEQ_W = 8;
    parameter int unsigned LA_W  = 3;

    // One outstanding instruction of a stream.
    typedef struct packed {
        logic             vld;
        logic [SEQ_W-1:0] seq;
        logic [SEQ_W-1:0] expiry;
    } slot_t;

    // True when nxt has reached or passed expiry, comparing modulo 2^SEQ_W.
    function automatic logic seq_reached(input logic [SEQ_W-1:0] nxt,
                                         input logic [SEQ_W-1:0] expiry);
        logic [SEQ_W-1:0] diff;
        diff = nxt - expiry;
        return ~diff[SEQ_W-1];
    endfunction
endpackage

// File: rtl/mt_stream_ctx.sv
// Per-stream context: the issue sequence counter and the table of outstanding
// instructions. Derives the stream's ready flag from the lookahead expiry rule.
// Assumes a grant only arrives while ready is high, and that a completion names
// an instruction that was issued earlier.
module mt_stream_ctx
    import mt_issue_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             inst_vld,
    input  logic [LA_W-1:0]  inst_la,
    input  logic             grant,
    input  logic             cmpl_hit,
    input  logic [SEQ_W-1:0] cmpl_seq,
    output logic             ready,
    output logic [SEQ_W-1:0] next_seq
);
    localparam int unsigned SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    slot_t             slots [DEPTH];
    logic [DEPTH-1:0]  occ;
    logic [DEPTH-1:0]  blk;
    logic [DEPTH-1:0]  hit;
    logic              full;
    logic [SLOT_W-1:0] free_idx;

    // Decode occupancy, expiry blocking, completion matches and the lowest free slot.
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            occ[i] = slots[i].vld;
            blk[i] = slots[i].vld && seq_reached(next_seq, slots[i].expiry);
            hit[i] = slots[i].vld && cmpl_hit && (slots[i].seq == cmpl_seq);
            if (!slots[i].vld) free_idx = SLOT_W'(i);
        end
        full  = &occ;
        ready = active && inst_vld && !full && !(|blk);
    end

    // Advance the sequence counter, allocate on grant and free on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_seq <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (hit[i]) slots[i].vld <= 1'b0;
            end
            if (grant) begin
                slots[free_idx].vld    <= 1'b1;
                slots[free_idx].seq    <= next_seq;
                slots[free_idx].expiry <= next_seq + SEQ_W'(inst_la) + SEQ_W'(1);
                next_seq               <= next_seq + SEQ_W'(1);
            end
        end
    end

    // R4: the picker grants only a stream that is ready.
    a_r4_grant_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ready);
    // R7: never allocate into a full table.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !full);
    // R3: the sequence number steps by one per issue and holds otherwise.
    a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> next_seq == $past(next_seq) + SEQ_W'(1));
    a_r3_seq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |=> $stable(next_seq));
    // R6: a matching completion frees exactly one entry.
    a_r6_cmpl_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> $countones(occ) == $past($countones(occ)) - 1 + int'($past(grant)));
endmodule

// File: rtl/mt_rr_picker.sv
// Round-robin picker: grants the first requester after the last granted index,
// wrapping around. The pointer starts at N-1 so index 0 is searched first.
// Assumes N is at least 2.
module mt_rr_picker #(
    parameter int unsigned N = 128,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             gnt_vld
);
    logic [IDX_W-1:0] last;

    // Search the requests in order, starting just after the last grant.
    always_comb begin
        int cand;
        gnt     = '0;
        gnt_idx = last;
        gnt_vld = 1'b0;
        for (int k = 1; k <= int'(N); k++) begin
            cand = int'(last) + k;
            if (cand >= int'(N)) cand = cand - int'(N);
            if (!gnt_vld && req[cand]) begin
                gnt_vld = 1'b1;
                gnt_idx = IDX_W'(cand);
            end
        end
        if (gnt_vld) gnt[gnt_idx] = 1'b1;
    end

    // Remember the last granted index.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= IDX_W'(N - 1);
        else if (gnt_vld) last <= gnt_idx;
    end

    // R2: at most one grant.
    a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R8: grants only go to requesters, and no cycle is idle while someone requests.
    a_r8_gnt_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    a_r8_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> gnt_vld);
endmodule

// File: rtl/mt_lookahead_issue.sv
// Issue stage for N instruction streams. One mt_stream_ctx per stream holds the
// lookahead interlock state; mt_rr_picker shares the single issue slot.
// Issue outputs are combinational; the stream state advances at the clock edge.
// Assumes completions name a stream id below N.
module mt_lookahead_issue
    import mt_issue_pkg::*;
#(
    parameter int unsigned N     = 128,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       strm_active,
    input  logic [N-1:0]       instr_valid,
    input  logic [N*LA_W-1:0]  instr_la,
    input  logic               cmpl_valid,
    input  logic [IDX_W-1:0]   cmpl_stream,
    input  logic [SEQ_W-1:0]   cmpl_seq,
    output logic               issue_valid,
    output logic [IDX_W-1:0]   issue_stream,
    output logic [SEQ_W-1:0]   issue_seq,
    output logic [LA_W-1:0]    issue_la
);
    logic [N-1:0]     rdy;
    logic [N-1:0]     gnt;
    logic [SEQ_W-1:0] nseq [N];

    // One context per stream.
    for (genvar s = 0; s < int'(N); s++) begin : g_strm
        mt_stream_ctx #(.DEPTH(DEPTH)) u_ctx (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (strm_active[s]),
            .inst_vld (instr_valid[s]),
            .inst_la  (instr_la[s*LA_W +: LA_W]),
            .grant    (gnt[s]),
            .cmpl_hit (cmpl_valid && (cmpl_stream == IDX_W'(s))),
            .cmpl_seq (cmpl_seq),
            .ready    (rdy[s]),
            .next_seq (nseq[s])
        );
    end

    mt_rr_picker #(.N(N)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (rdy),
        .gnt     (gnt),
        .gnt_idx (issue_stream),
        .gnt_vld (issue_valid)
    );

    // Report the granted stream's sequence number and lookahead.
    always_comb begin
        issue_seq = nseq[issue_stream];
        issue_la  = instr_la[issue_stream*LA_W +: LA_W];
    end

    // R9: an issuing stream is active and holds a valid instruction.
    a_r9_only_live: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (strm_active[issue_stream] && instr_valid[issue_stream]));
endmodule

// File: tb/tb_mt_lookahead_issue.sv
module tb_mt_lookahead_issue;
    localparam int NS = 128;
    localparam int DP = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NS-1:0]    act = '0;
    logic [NS-1:0]    ivld = '0;
    logic [NS*3-1:0]  la = '0;
    logic             cv = 1'b0;
    logic [6:0]       cs = '0;
    logic [7:0]       cq = '0;
    logic             iv;
    logic [6:0]       istr;
    logic [7:0]       iseq;
    logic [2:0]       ila;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model, full-width integers (no wrap).
    int m_next [NS];
    int m_seq  [NS][DP];
    int m_exp  [NS][DP];
    bit m_v    [NS][DP];
    int m_last;
    int la_cur [NS];

    always #4 clk = ~clk;

    mt_lookahead_issue dut (
        .clk(clk), .rst_n(rst_n), .strm_active(act), .instr_valid(ivld),
        .instr_la(la), .cmpl_valid(cv), .cmpl_stream(cs), .cmpl_seq(cq),
        .issue_valid(iv), .issue_stream(istr), .issue_seq(iseq), .issue_la(ila)
    );

    task automatic chk(input string tag, input int actual, input int expect_v);
        checks++;
        if (actual != expect_v) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, actual, expect_v);
        end
    endtask

    // R4/R5: blocked if any outstanding entry expires at or before next index.
    // R7: blocked if DP entries are outstanding.
    function automatic bit m_ready(input int s);
        int cnt;
        bit blk;
        cnt = 0;
        blk = 0;
        for (int i = 0; i < DP; i++) begin
            if (m_v[s][i]) begin
                cnt++;
                if (m_exp[s][i] <= m_next[s]) blk = 1;
            end
        end
        return act[s] && ivld[s] && !blk && (cnt < DP);
    endfunction

    // R8: first ready stream after the last issued one.
    function automatic int m_pick();
        for (int k = 1; k <= NS; k++) begin
            int c;
            c = (m_last + k) % NS;
            if (m_ready(c)) return c;
        end
        return -1;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_next[s] = 0;
            la_cur[s] = $urandom_range(0, 7);
            for (int i = 0; i < DP; i++) m_v[s][i] = 0;
        end
        m_last = NS - 1;
    endtask

    task automatic drive_la();
        for (int s = 0; s < NS; s++) la[s*3 +: 3] = 3'(la_cur[s]);
    endtask

    // Choose a completion: mostly a real outstanding entry, sometimes a bogus one (R6).
    task automatic pick_cmpl(input int pct);
        int s0;
        int found;
        cv = 1'b0;
        if ($urandom_range(0, 99) >= pct) return;
        s0 = $urandom_range(0, NS - 1);
        if ($urandom_range(0, 7) == 0) begin
            cv = 1'b1; cs = 7'(s0); cq = 8'(m_next[s0]);
            return;
        end
        found = -1;
        for (int k = 0; k < NS && found < 0; k++) begin
            int s;
            s = (s0 + k) % NS;
            for (int i = 0; i < DP; i++) if (m_v[s][i]) found = s;
        end
        if (found < 0) return;
        begin
            int i0;
            i0 = $urandom_range(0, DP - 1);
            for (int k = 0; k < DP; k++) begin
                int i;
                i = (i0 + k) % DP;
                if (m_v[found][i] && !cv) begin
                    cv = 1'b1; cs = 7'(found); cq = 8'(m_seq[found][i]);
                end
            end
        end
    endtask

    // One cycle: inputs already driven at negedge; check, then mirror the edge.
    task automatic step_check();
        int e;
        #1;
        e = m_pick();
        chk("R1/R2/R4/R6/R7/R9 issue_valid", int'(iv), int'(e >= 0));
        if (e >= 0 && iv) begin
            chk("R8 issue_stream", int'(istr), e);
            chk("R3 issue_seq", int'(iseq), m_next[e] % 256);
            chk("R5 issue_la", int'(ila), la_cur[e]);
        end
        // R6: completion removes the matching entry only.
        if (cv) begin
            for (int i = 0; i < DP; i++)
                if (m_v[cs][i] && (m_seq[cs][i] % 256) == int'(cq)) m_v[cs][i] = 0;
        end
        if (e >= 0) begin
            bit placed;
            placed = 0;
            for (int i = 0; i < DP; i++) begin
                if (!m_v[e][i] && !placed) begin
                    m_v[e][i] = 1; m_seq[e][i] = m_next[e];
                    m_exp[e][i] = m_next[e] + la_cur[e] + 1;
                    placed = 1;
                end
            end
            m_next[e]++;
            m_last = e;
            la_cur[e] = $urandom_range(0, 7);
        end
    endtask

    task automatic run_phase(input int cycles, input bit [NS-1:0] amask,
                             input int vpct, input int cpct);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            for (int s = 0; s < NS; s++) begin
                act[s]  = amask[s];
                ivld[s] = ($urandom_range(0, 99) < vpct);
            end
            drive_la();
            pick_cmpl(cpct);
            step_check();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        drive_la();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: nothing active after reset, nothing issues.
        #1;
        chk("R1 idle after reset", int'(iv), 0);

        // Directed R5: stream 9 with lookahead 7, no completions: 7 follow-ons then stall.
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            act = '0; ivld = '0; act[9] = 1'b1; ivld[9] = 1'b1;
            la_cur[9] = 7;
            drive_la();
            cv = 1'b0;
            step_check();
        end
        chk("R5 eight issued before stall", m_next[9], 8);
        // R6 bogus completion for a sequence not yet issued: stream stays blocked.
        @(negedge clk);
        cv = 1'b1; cs = 7'd9; cq = 8'd8;
        step_check();
        @(negedge clk);
        cv = 1'b0;
        step_check();
        chk("R6 bogus completion ignored", m_next[9], 8);

        // Single stream long run: sequence wrap past 256 (R3).
        begin
            bit [NS-1:0] m;
            m = '0; m[9] = 1'b1;
            run_phase(900, m, 90, 100);
        end
        // Few streams incl. the wrap 127 -> 0 (R8), sparse completions.
        begin
            bit [NS-1:0] m;
            m = '0; m[0] = 1'b1; m[1] = 1'b1; m[126] = 1'b1; m[127] = 1'b1;
            run_phase(600, m, 80, 40);
        end
        // All streams, random validity (R9).
        run_phase(3000, {NS{1'b1}}, 70, 90);
        // Random active subsets.
        for (int r = 0; r < 4; r++) begin
            bit [NS-1:0] m;
            for (int s = 0; s < NS; s++) m[s] = ($urandom_range(0, 3) == 0);
            run_phase(500, m, 60, 70);
        end
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule